// File: doc/BRIEF.md
# Canonical address fault classifier

This block checks every 64-bit linear address that a memory access presents in 64-bit mode. It decides whether the address is in canonical form for the paging depth in force. When the address is not canonical, it decides which exception the access raises. An address is canonical when all of its bits above the implemented virtual width are copies of the top implemented bit. That top implemented bit is bit 47 with four-level paging and bit 56 with five-level paging.

Some accesses go through the stack. These are push and pop operations, and any address whose base register is the stack pointer or the frame pointer. When such an access is non-canonical, it raises the stack-fault vector. Every other non-canonical access raises general protection. The verdict is registered and comes out as a one-cycle pulse, together with the vector and a zero error code.

Top module: `canon_fault_classifier`

## Requirements
- R1: With `five_level_i` low, an access is canonical exactly when address bits 63 to 47 all hold the same value. A non-canonical access raises a fault.
- R2: With `five_level_i` high, an access is canonical exactly when address bits 63 to 56 all hold the same value. Bits 55 to 47 are free. The mode is sampled on the same cycle as the address.
- R3: A non-canonical access with `base_vld_i` high and `base_idx_i` equal to 4 (stack pointer) raises vector 12.
- R4: A non-canonical access with `base_vld_i` high and `base_idx_i` equal to 5 (frame pointer) raises vector 12.
- R5: A non-canonical access with `stack_op_i` high raises vector 12, whatever the base-register inputs are.
- R6: Every other non-canonical access raises vector 13. This covers any other index, and any access with `base_vld_i` low, including index 4 or 5 with `base_vld_i` low.
- R7: The error code is 0 whenever `fault_vld_o` is high.
- R8: A canonical access produces no fault. `fault_vld_o` stays low for it.
- R9: For each accepted access, `fault_vld_o` rises exactly one cycle after `acc_valid_i` and lasts one cycle. A cycle with `acc_valid_i` low raises nothing, whatever the address. `fault_vec_o` changes only together with a pulse and otherwise holds its last value.
- R10: When `rst_ni` is low, `fault_vld_o`, `fault_vec_o` and `fault_err_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Access present this cycle |
| addr_i | input | 64 | Linear address of the access |
| five_level_i | input | 1 | Five-level paging in force |
| base_vld_i | input | 1 | The address has a base register |
| base_idx_i | input | 4 | Base register index (4 = stack pointer, 5 = frame pointer) |
| stack_op_i | input | 1 | Implied stack reference (push or pop) |
| fault_vld_o | output | 1 | One-cycle fault pulse |
| fault_vec_o | output | 8 | Exception vector: 12 stack fault, 13 general protection |
| fault_err_o | output | 16 | Error code, always zero |

## Verification
The sweep targets these corner cases:
- Single-bit flips and sign-extension edges at every bit position, under both paging depths. A checker that looked at the wrong boundary bit would misjudge the addresses that differ only at bit 47 or bit 56. A checker that ignored the mode would fault on five-level addresses whose bits 55 to 47 differ.
- Every base index, with and without the base-present flag and the stack flag. A design that decoded the index while the base-present flag was low, or that missed the frame pointer, would report 12 where 13 is due, or the reverse.
- The idle cycle after each access, with the non-canonical address still on the inputs. This exposes a design that faults without the valid strobe, stretches the pulse, or disturbs the held vector.

// File: rtl/canon_pkg.sv
package canon_pkg;
  localparam int unsigned VEC_W = 8;
  localparam int unsigned ERR_W = 16;
  localparam int unsigned IDX_W = 4;
  typedef logic [VEC_W-1:0] vec_t;
  typedef logic [ERR_W-1:0] err_t;
  typedef logic [IDX_W-1:0] idx_t;
  localparam vec_t VEC_STACK = 8'd12;
  localparam vec_t VEC_GPROT = 8'd13;
  localparam idx_t IDX_SP    = 4'd4;
  localparam idx_t IDX_FP    = 4'd5;
  localparam err_t ERR_NONE  = '0;
endpackage

// File: rtl/canon_check.sv
// Canonical test for one paging depth: everything from TOP_LSB up must match.
module canon_check #(
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned TOP_LSB = 47
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              canon_o
);
  logic signed [ADDR_W-1:0] sext;
  always_comb begin
    sext    = $signed(addr_i) >>> TOP_LSB;
    canon_o = (&sext) | ~(|sext);
  end
endmodule

// File: rtl/canon_vec_sel.sv
module canon_vec_sel import canon_pkg::*; (
  input  logic base_vld_i,
  input  idx_t base_idx_i,
  input  logic stack_op_i,
  output vec_t vec_o
);
  logic stack_based;
  always_comb begin
    stack_based = stack_op_i |
                  (base_vld_i & ((base_idx_i == IDX_SP) | (base_idx_i == IDX_FP)));
    vec_o = stack_based ? VEC_STACK : VEC_GPROT;
  end
endmodule

// File: rtl/canon_fault_classifier.sv
module canon_fault_classifier import canon_pkg::*; #(
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned VA_BITS4 = 48,
  parameter int unsigned VA_BITS5 = 57
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              five_level_i,
  input  logic              base_vld_i,
  input  logic [IDX_W-1:0]  base_idx_i,
  input  logic              stack_op_i,
  output logic              fault_vld_o,
  output logic [VEC_W-1:0]  fault_vec_o,
  output logic [ERR_W-1:0]  fault_err_o
);
  localparam int unsigned NUM_DEPTHS = 2;
  localparam int unsigned LSB4 = VA_BITS4 - 1;
  localparam int unsigned LSB5 = VA_BITS5 - 1;

  logic [NUM_DEPTHS-1:0] canon_d;
  logic                  is_canon;
  logic                  fault_d;
  vec_t                  vec_d;

  for (genvar g = 0; g < NUM_DEPTHS; g++) begin : g_depth
    canon_check #(
      .ADDR_W (ADDR_W),
      .TOP_LSB((g == 0) ? LSB4 : LSB5)
    ) i_chk (
      .addr_i (addr_i),
      .canon_o(canon_d[g])
    );
  end

  canon_vec_sel i_sel (
    .base_vld_i(base_vld_i),
    .base_idx_i(base_idx_i),
    .stack_op_i(stack_op_i),
    .vec_o     (vec_d)
  );

  assign is_canon = five_level_i ? canon_d[1] : canon_d[0];
  assign fault_d  = acc_valid_i & ~is_canon;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_vld_o <= 1'b0;
      fault_vec_o <= '0;
      fault_err_o <= '0;
    end else begin
      fault_vld_o <= fault_d;
      if (fault_d) begin
        fault_vec_o <= vec_d;
        fault_err_o <= ERR_NONE;
      end
    end
  end
endmodule

// File: rtl/canon_fault_classifier_chk.sv
module canon_fault_classifier_chk import canon_pkg::*; (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             acc_valid_i,
  input logic [63:0]      addr_i,
  input logic             five_level_i,
  input logic             base_vld_i,
  input logic [IDX_W-1:0] base_idx_i,
  input logic             stack_op_i,
  input logic             fault_vld_o,
  input logic [VEC_W-1:0] fault_vec_o,
  input logic [ERR_W-1:0] fault_err_o
);
  AST_PULSE_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_vld_o |-> $past(acc_valid_i)); // R9
  AST_VEC_ONLY_ON_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_vec_o != $past(fault_vec_o)) |-> fault_vld_o); // R9
  AST_ERR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_vld_o |-> (fault_err_o == '0)); // R7
  AST_VEC_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_vld_o |-> (fault_vec_o == 8'd12 || fault_vec_o == 8'd13)); // R6
  AST_STACK_OP_SS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && stack_op_i) |=> (!fault_vld_o || fault_vec_o == 8'd12)); // R5
  AST_SP_BASE_SS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && base_vld_i && base_idx_i == 4'd4) |=> (!fault_vld_o || fault_vec_o == 8'd12)); // R3
  AST_FP_BASE_SS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && base_vld_i && base_idx_i == 4'd5) |=> (!fault_vld_o || fault_vec_o == 8'd12)); // R4
  AST_CANON4_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !five_level_i && (addr_i[63:47] == '0 || addr_i[63:47] == '1)) |=> !fault_vld_o); // R1
  AST_CANON5_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && five_level_i && (addr_i[63:56] == '0 || addr_i[63:56] == '1)) |=> !fault_vld_o); // R2
endmodule

bind canon_fault_classifier canon_fault_classifier_chk i_canon_chk (.*);

// File: tb/test_canon_fault_classifier.sv
module test_canon_fault_classifier;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        acc_valid_i = 1'b0;
  logic [63:0] addr_i = '0;
  logic        five_level_i = 1'b0;
  logic        base_vld_i = 1'b0;
  logic [3:0]  base_idx_i = '0;
  logic        stack_op_i = 1'b0;
  logic        fault_vld_o;
  logic [7:0]  fault_vec_o;
  logic [15:0] fault_err_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] held_vec = 8'd0;

  always #2.5 clk_i = ~clk_i;

  canon_fault_classifier i_canon_fault_classifier (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit is_canon(input logic [63:0] a, input bit five);
    int lsb = five ? 56 : 47;
    for (int b = lsb + 1; b < 64; b++)
      if (a[b] != a[lsb]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [63:0] pattern(input int k, input int kind);
    logic [63:0] one = 64'd1 << k;
    case (kind)
      0: return one;
      1: return ~one;
      2: return ~(one - 64'd1);
      default: return one - 64'd1;
    endcase
  endfunction

  task automatic access(input logic [63:0] a, input bit five, input bit bv,
                        input logic [3:0] idx, input bit sop);
    bit    exp_f;
    logic [7:0] exp_v;
    string mt, vt;
    @(negedge clk_i);
    acc_valid_i = 1'b1; addr_i = a; five_level_i = five;
    base_vld_i = bv; base_idx_i = idx; stack_op_i = sop;
    exp_f = !is_canon(a, five);
    mt = five ? "R2" : "R1";
    if (sop) begin exp_v = 8'd12; vt = "R5"; end
    else if (bv && idx == 4'd4) begin exp_v = 8'd12; vt = "R3"; end
    else if (bv && idx == 4'd5) begin exp_v = 8'd12; vt = "R4"; end
    else begin exp_v = 8'd13; vt = "R6"; end
    @(negedge clk_i);
    acc_valid_i = 1'b0;
    if (exp_f) begin
      chk({mt, " fault pulse"}, fault_vld_o, 1);
      chk({vt, " vector"}, fault_vec_o, exp_v);
      chk("R7 error code", fault_err_o, 0);
      held_vec = exp_v;
    end else begin
      chk({"R8 canonical no fault ", mt}, fault_vld_o, 0);
      chk("R9 vector held", fault_vec_o, held_vec);
    end
    @(negedge clk_i);
    chk("R9 single pulse, idle ignored", fault_vld_o, 0);
    chk("R9 vector held idle", fault_vec_o, held_vec);
  endtask

  initial begin
    repeat (195000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1;
    chk("R10 reset fault_vld", fault_vld_o, 0);
    chk("R10 reset vec", fault_vec_o, 0);
    chk("R10 reset err", fault_err_o, 0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    for (int five = 0; five < 2; five++)
      for (int k = 0; k < 64; k++)
        for (int kind = 0; kind < 4; kind++)
          for (int c = 0; c < 64; c++)
            access(pattern(k, kind), five[0], c[5], c[3:0], c[4]);
    // boundary cases: differences exactly at bit 47 and 56
    access(64'h0000_8000_0000_0000, 1'b0, 1'b1, 4'd4, 1'b0);
    access(64'h0000_8000_0000_0000, 1'b1, 1'b1, 4'd4, 1'b0);
    access(64'h00FF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 4'd5, 1'b0);
    access(64'h0100_0000_0000_0000, 1'b1, 1'b0, 4'd5, 1'b0);
    // async reset mid-run after a fault
    access(64'h8000_0000_0000_0000, 1'b0, 1'b0, 4'd0, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R10 mid reset fault_vld", fault_vld_o, 0);
    chk("R10 mid reset vec", fault_vec_o, 0);
    chk("R10 mid reset err", fault_err_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule